// File: doc/BRIEF.md
# Linked Frame Descriptor Fetcher

This block sequences the per-frame setup of a multi-channel display controller. Each channel owns a chain of four-word descriptors held in memory. When the controller pulses its frame-start input, the block walks through the enabled channels one at a time, lowest number first. For each one it picks a descriptor address and reads the descriptor through a single word-wide read port. It then stores the link, source, ID and command words and reports the frame events that the command word asks for.

Software can redirect a channel for one frame by posting a branch address with a request flag. The next frame start takes the descriptor from that address and clears the flag in hardware, so later frames follow the chain again. Descriptor and source addresses are checked against one memory window. A descriptor address outside the window is not fetched. A bad source address is reported as a bus error for that channel. Event pulses go to a separate interrupt block. Each pulse carries the channel number, and no two pulses share a cycle.

Top module: `frame_desc_fetcher`

## Requirements
- R1: After reset, busy, mem_req and all event outputs are low, and every register reads 0.
- R2: A write to the link register (offset 0x00) stores the value with bits 3:0 forced to 0. A write to the branch register (offset 0x04) stores the value ANDed with 0xFFFFFFF3. Writes to source (0x08), ID (0x0C) and command (0x10) have no effect. Channel c's registers are at byte address c*0x20 + offset.
- R3: At a frame start, if branch bit 0 (request) of an enabled channel is set, the descriptor is read from the branch value with bits 3:0 cleared, and bit 0 is cleared while bit 1 is kept. A branch event for that channel is pulsed only when bit 1 (branch interrupt) is also set.
- R4: Without a branch request, the descriptor is read from the link register. Its words are link, source, ID and command, in that order. They become visible in the registers only after all four have arrived.
- R5: If the descriptor address is below the window base, or the address plus 16 exceeds base plus size, no read is issued. The link register is then left unchanged, the source register reads 0, and a bus-error event names the channel.
- R6: A source address of zero, or one outside [base, base+size), pulses a bus-error event for the channel, and no start-of-frame or end-of-frame event is raised for that channel.
- R7: A start-of-frame event is raised only when command bit 22 is set. An end-of-frame event follows it, in a later cycle, only when command bit 21 is set.
- R8: Enabled channels are serviced in ascending number. Disabled channels issue no reads and keep their registers.
- R9: busy rises in the cycle after frame_start and falls after the last enabled channel finishes. A frame_start seen while busy is ignored.
- R10: mem_req stays high with a stable mem_addr until mem_valid. The four words of a descriptor are requested at its address plus 0, 4, 8 and 12, in that order.
- R11: At most one of the four event outputs is high in any cycle, and evt_ch carries the channel number it refers to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle frame start pulse |
| ch_en | input | NUM_CH | Per-channel enable |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | 32 | Descriptor word byte address |
| mem_valid | input | 1 | Read data valid, accepts the request |
| mem_data | input | 32 | Read data |
| busy | output | 1 | Frame setup in progress |
| evt_sof | output | 1 | Start-of-frame event pulse |
| evt_eof | output | 1 | End-of-frame event pulse |
| evt_bs | output | 1 | Branch event pulse |
| evt_ber | output | 1 | Bus-error event pulse |
| evt_ch | output | 3 | Channel number of the current event |

## Verification
The bench first runs one channel through its chain across frames with the command bits set in different ways: both events, end only, then none. This separates event gating from the fetch itself. Branch requests with and without the interrupt flag show whether the one-shot redirect and its flag clearing are kept apart from event generation. Descriptor addresses just inside and just outside both window edges, and zero or out-of-window source words, separate the skipped-load path from the bus-error path. A final frame uses three channels with a gap in the enables, a stalling memory and a repeated frame start. It checks ordering, handshake hold and the single-event rule together.

// File: rtl/fdf_pkg.sv
package fdf_pkg;
   localparam int MAX_CH     = 7;
   localparam int CH_IDX_W   = 3;
   localparam int CH_SLOTS   = 1 << CH_IDX_W;
   localparam int DESC_WORDS = 4;
   localparam int DESC_BYTES = DESC_WORDS * 4;

   localparam int CMD_EOF_BIT = 21;
   localparam int CMD_SOF_BIT = 22;
   localparam int BR_REQ_BIT  = 0;
   localparam int BR_INT_BIT  = 1;

   localparam logic [31:0] BR_WMASK  = 32'hFFFF_FFF3;
   localparam logic [31:0] LNK_WMASK = 32'hFFFF_FFF0;

   typedef enum logic [2:0] {
      OFS_LNK = 3'd0,
      OFS_BRA = 3'd1,
      OFS_SRC = 3'd2,
      OFS_ID  = 3'd3,
      OFS_CMD = 3'd4
   } reg_ofs_e;

   typedef enum logic [2:0] {
      ST_IDLE, ST_PICK, ST_LOAD, ST_FETCH, ST_CHECK, ST_EOF
   } seq_st_e;

   typedef struct packed {
      logic [31:0] lnk;
      logic [31:0] src;
      logic [31:0] id;
      logic [31:0] cmd;
   } desc_t;

   function automatic logic desc_in_win(input logic [31:0] a,
                                        input logic [31:0] base,
                                        input logic [31:0] size);
      return ({1'b0, a} >= {1'b0, base}) &&
             ({1'b0, a} + 33'(DESC_BYTES) <= {1'b0, base} + {1'b0, size});
   endfunction

   function automatic logic src_in_win(input logic [31:0] a,
                                       input logic [31:0] base,
                                       input logic [31:0] size);
      return (a != 32'd0) && ({1'b0, a} >= {1'b0, base}) &&
             ({1'b0, a} < {1'b0, base} + {1'b0, size});
   endfunction
endpackage

// File: rtl/fdf_desc_fetch.sv
module fdf_desc_fetch
   import fdf_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [AW-1:0] go_addr,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   input  logic          mem_valid,
   input  logic [31:0]   mem_data,
   output logic          done,
   output desc_t         desc
);
   localparam int IDX_W = $clog2(DESC_WORDS);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(DESC_WORDS - 1);

   generate
      if (DESC_WORDS != 4) begin : g_bad_words
         $error("fdf_desc_fetch assumes a four-word descriptor");
      end
   endgenerate

   logic                          active;
   logic [IDX_W-1:0]              idx;
   logic [AW-1:0]                 base;
   logic [DESC_WORDS-2:0][31:0]   hold;

   assign mem_req  = active;
   assign mem_addr = base + AW'({idx, 2'b00});
   assign done     = active && mem_valid && (idx == LAST);

   // Words are exposed together only on the final beat.
   assign desc.lnk = hold[0];
   assign desc.src = hold[1];
   assign desc.id  = hold[2];
   assign desc.cmd = mem_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         idx    <= '0;
         base   <= '0;
         hold   <= '0;
      end else if (!active) begin
         if (go) begin
            active <= 1'b1;
            idx    <= '0;
            base   <= go_addr;
         end
      end else if (mem_valid) begin
         if (idx == LAST) begin
            active <= 1'b0;
         end else begin
            hold[idx] <= mem_data;
            idx       <= idx + 1'b1;
         end
      end
   end

   // R10: request held with a fixed address until accepted
   a_r10_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

   // R10: words requested at consecutive word addresses
   a_r10_word_step: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_valid && !done) |=> (mem_addr == $past(mem_addr) + AW'(4)));
endmodule

// File: rtl/fdf_chan_regs.sv
module fdf_chan_regs
   import fdf_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_lnk,
   input  logic        wr_bra,
   input  logic [31:0] wdata,
   input  logic        clr_src,
   input  logic        clr_bra,
   input  logic        commit,
   input  desc_t       d_in,
   output logic [31:0] lnk,
   output logic [31:0] bra,
   output logic [31:0] src,
   output logic [31:0] id,
   output logic [31:0] cmd
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lnk <= '0;
         bra <= '0;
         src <= '0;
         id  <= '0;
         cmd <= '0;
      end else begin
         if (commit) begin
            lnk <= d_in.lnk;
            src <= d_in.src;
            id  <= d_in.id;
            cmd <= d_in.cmd;
         end else if (clr_src) begin
            src <= '0;
         end
         // Software write to the link register wins over a descriptor load.
         if (wr_lnk) lnk <= wdata & LNK_WMASK;
         if (wr_bra) bra <= wdata & BR_WMASK;
         else if (clr_bra) bra[BR_REQ_BIT] <= 1'b0;
      end
   end

   // R2: stored link pointer is 16-byte aligned after a write
   a_r2_lnk_align: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lnk |=> (lnk[3:0] == 4'd0));

   // R2: reserved branch bits are zero after a write
   a_r2_bra_mask: assert property (@(posedge clk) disable iff (!rst_n)
      wr_bra |=> (bra[3:2] == 2'd0));

   // R3: branch request is one-shot
   a_r3_bra_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_bra && !wr_bra) |=> !bra[BR_REQ_BIT]);
endmodule

// File: rtl/fdf_seq.sv
module fdf_seq
   import fdf_pkg::*;
#(
   parameter int          NUM_CH   = 4,
   parameter logic [31:0] MEM_BASE = 32'hA000_0000,
   parameter logic [31:0] MEM_SIZE = 32'h0400_0000
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          frame_start,
   input  logic [CH_SLOTS-1:0]           ch_en,
   input  logic [CH_SLOTS-1:0][31:0]     lnk_all,
   input  logic [CH_SLOTS-1:0][31:0]     bra_all,
   input  logic [CH_SLOTS-1:0][31:0]     src_all,
   input  logic [CH_SLOTS-1:0][31:0]     cmd_all,
   input  logic                          fetch_done,
   output logic                          fetch_go,
   output logic [31:0]                   fetch_addr,
   output logic [CH_SLOTS-1:0]           clr_src,
   output logic [CH_SLOTS-1:0]           clr_bra,
   output logic [CH_SLOTS-1:0]           commit,
   output logic                          busy,
   output logic                          evt_sof,
   output logic                          evt_eof,
   output logic                          evt_bs,
   output logic                          evt_ber,
   output logic [CH_IDX_W-1:0]           evt_ch
);
   seq_st_e               st;
   logic [CH_IDX_W-1:0]   cur;
   logic [CH_IDX_W-1:0]   pick;
   logic                  found;
   logic                  br_req;
   logic                  br_int;
   logic                  d_ok;
   logic                  s_ok;
   logic [31:0]           cmd_cur;

   // Lowest enabled channel at or above the cursor.
   always_comb begin
      found = 1'b0;
      pick  = cur;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (ch_en[i] && (CH_IDX_W'(i) >= cur)) begin
            found = 1'b1;
            pick  = CH_IDX_W'(i);
         end
      end
   end

   always_comb begin
      br_req     = bra_all[cur][BR_REQ_BIT];
      br_int     = bra_all[cur][BR_INT_BIT];
      fetch_addr = br_req ? {bra_all[cur][31:4], 4'b0000} : lnk_all[cur];
      d_ok       = desc_in_win(fetch_addr, MEM_BASE, MEM_SIZE);
      s_ok       = src_in_win(src_all[cur], MEM_BASE, MEM_SIZE);
      cmd_cur    = cmd_all[cur];
      fetch_go   = 1'b0;
      clr_src    = '0;
      clr_bra    = '0;
      commit     = '0;
      if (st == ST_LOAD) begin
         clr_src[cur] = 1'b1;
         clr_bra[cur] = br_req;
         fetch_go     = d_ok;
      end
      if (st == ST_FETCH && fetch_done) commit[cur] = 1'b1;
   end

   assign busy = (st != ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cur     <= '0;
         evt_sof <= 1'b0;
         evt_eof <= 1'b0;
         evt_bs  <= 1'b0;
         evt_ber <= 1'b0;
         evt_ch  <= '0;
      end else begin
         evt_sof <= 1'b0;
         evt_eof <= 1'b0;
         evt_bs  <= 1'b0;
         evt_ber <= 1'b0;
         unique case (st)
            ST_IDLE: if (frame_start) begin
               cur <= '0;
               st  <= ST_PICK;
            end
            ST_PICK: if (found) begin
               cur <= pick;
               st  <= ST_LOAD;
            end else begin
               st  <= ST_IDLE;
            end
            ST_LOAD: begin
               evt_bs <= br_req && br_int;
               evt_ch <= cur;
               st     <= d_ok ? ST_FETCH : ST_CHECK;
            end
            ST_FETCH: if (fetch_done) st <= ST_CHECK;
            ST_CHECK: begin
               evt_ch <= cur;
               if (!s_ok) begin
                  evt_ber <= 1'b1;
                  cur     <= cur + 1'b1;
                  st      <= ST_PICK;
               end else begin
                  evt_sof <= cmd_cur[CMD_SOF_BIT];
                  st      <= ST_EOF;
               end
            end
            ST_EOF: begin
               evt_eof <= cmd_cur[CMD_EOF_BIT];
               evt_ch  <= cur;
               cur     <= cur + 1'b1;
               st      <= ST_PICK;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R11: events never coincide
   a_r11_one_event: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({evt_sof, evt_eof, evt_bs, evt_ber}));

   // R6: a bus error is not followed by a frame-start event
   a_r6_ber_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      evt_ber |=> !evt_sof);

   // R8: only enabled channels are loaded
   a_r8_load_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_LOAD) |-> ch_en[cur]);

   // R9: a frame start during a pass does not restart the cursor
   a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && st != ST_EOF && st != ST_CHECK && st != ST_PICK) |=> (cur == $past(cur)));
endmodule

// File: rtl/frame_desc_fetcher.sv
module frame_desc_fetcher
   import fdf_pkg::*;
#(
   parameter int          NUM_CH   = 4,
   parameter logic [31:0] MEM_BASE = 32'hA000_0000,
   parameter logic [31:0] MEM_SIZE = 32'h0400_0000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 frame_start,
   input  logic [NUM_CH-1:0]    ch_en,
   input  logic                 reg_we,
   input  logic [7:0]           reg_addr,
   input  logic [31:0]          reg_wdata,
   output logic [31:0]          reg_rdata,
   output logic                 mem_req,
   output logic [31:0]          mem_addr,
   input  logic                 mem_valid,
   input  logic [31:0]          mem_data,
   output logic                 busy,
   output logic                 evt_sof,
   output logic                 evt_eof,
   output logic                 evt_bs,
   output logic                 evt_ber,
   output logic [2:0]           evt_ch
);
   generate
      if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_ch
         $error("NUM_CH must lie in 1..7");
      end
      if (MEM_BASE[3:0] != 4'd0) begin : g_bad_base
         $error("MEM_BASE must be 16-byte aligned");
      end
   endgenerate

   logic [CH_SLOTS-1:0]        en_pad;
   logic [CH_SLOTS-1:0][31:0]  lnk_all, bra_all, src_all, id_all, cmd_all;
   logic [CH_SLOTS-1:0]        clr_src, clr_bra, commit;
   logic                       fetch_go, fetch_done;
   logic [31:0]                fetch_addr;
   desc_t                      desc;
   logic [CH_IDX_W-1:0]        sel_ch;
   reg_ofs_e                   sel_ofs;

   assign en_pad  = {{(CH_SLOTS - NUM_CH){1'b0}}, ch_en};
   assign sel_ch  = reg_addr[7:5];
   assign sel_ofs = reg_ofs_e'(reg_addr[4:2]);

   for (genvar g = 0; g < CH_SLOTS; g++) begin : g_ch
      if (g < NUM_CH) begin : g_live
         logic wr_lnk_g, wr_bra_g;
         assign wr_lnk_g = reg_we && (sel_ch == CH_IDX_W'(g)) && (sel_ofs == OFS_LNK);
         assign wr_bra_g = reg_we && (sel_ch == CH_IDX_W'(g)) && (sel_ofs == OFS_BRA);
         fdf_chan_regs u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_lnk  (wr_lnk_g),
            .wr_bra  (wr_bra_g),
            .wdata   (reg_wdata),
            .clr_src (clr_src[g]),
            .clr_bra (clr_bra[g]),
            .commit  (commit[g]),
            .d_in    (desc),
            .lnk     (lnk_all[g]),
            .bra     (bra_all[g]),
            .src     (src_all[g]),
            .id      (id_all[g]),
            .cmd     (cmd_all[g])
         );
      end else begin : g_absent
         assign lnk_all[g] = '0;
         assign bra_all[g] = '0;
         assign src_all[g] = '0;
         assign id_all[g]  = '0;
         assign cmd_all[g] = '0;
      end
   end

   always_comb begin
      unique case (sel_ofs)
         OFS_LNK: reg_rdata = lnk_all[sel_ch];
         OFS_BRA: reg_rdata = bra_all[sel_ch];
         OFS_SRC: reg_rdata = src_all[sel_ch];
         OFS_ID:  reg_rdata = id_all[sel_ch];
         OFS_CMD: reg_rdata = cmd_all[sel_ch];
         default: reg_rdata = '0;
      endcase
   end

   fdf_seq #(
      .NUM_CH   (NUM_CH),
      .MEM_BASE (MEM_BASE),
      .MEM_SIZE (MEM_SIZE)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .ch_en       (en_pad),
      .lnk_all     (lnk_all),
      .bra_all     (bra_all),
      .src_all     (src_all),
      .cmd_all     (cmd_all),
      .fetch_done  (fetch_done),
      .fetch_go    (fetch_go),
      .fetch_addr  (fetch_addr),
      .clr_src     (clr_src),
      .clr_bra     (clr_bra),
      .commit      (commit),
      .busy        (busy),
      .evt_sof     (evt_sof),
      .evt_eof     (evt_eof),
      .evt_bs      (evt_bs),
      .evt_ber     (evt_ber),
      .evt_ch      (evt_ch)
   );

   fdf_desc_fetch #(.AW(32)) u_fetch (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (fetch_go),
      .go_addr   (fetch_addr),
      .mem_req   (mem_req),
      .mem_addr  (mem_addr),
      .mem_valid (mem_valid),
      .mem_data  (mem_data),
      .done      (fetch_done),
      .desc      (desc)
   );

   // R9: no memory traffic outside a frame pass
   a_r9_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req);

   // R5: every descriptor word read lies inside the window
   a_r5_req_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (({1'b0, mem_addr} >= {1'b0, MEM_BASE}) &&
                   ({1'b0, mem_addr} < {1'b0, MEM_BASE} + {1'b0, MEM_SIZE})));

   // R11: event channel always names an existing channel
   a_r11_evt_ch_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_sof || evt_eof || evt_bs || evt_ber) |-> (32'(evt_ch) < NUM_CH));
endmodule

// File: tb/frame_desc_fetcher_tb_top.sv
module frame_desc_fetcher_tb_top;
   localparam int          NCH  = 4;
   localparam logic [31:0] BASE = 32'h0000_1000;
   localparam logic [31:0] SIZE = 32'h0000_0400;
   localparam int K_SOF = 1, K_EOF = 2, K_BS = 3, K_BER = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frame_start = 1'b0;
   logic [NCH-1:0] ch_en = '0;
   logic reg_we = 1'b0;
   logic [7:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic mem_req;
   logic [31:0] mem_addr;
   logic mem_valid = 1'b0;
   logic [31:0] mem_data = '0;
   logic busy, evt_sof, evt_eof, evt_bs, evt_ber;
   logic [2:0] evt_ch;

   always #5 clk = ~clk;

   frame_desc_fetcher #(.NUM_CH(NCH), .MEM_BASE(BASE), .MEM_SIZE(SIZE)) dut_i (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .ch_en(ch_en),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_data(mem_data),
      .busy(busy), .evt_sof(evt_sof), .evt_eof(evt_eof), .evt_bs(evt_bs),
      .evt_ber(evt_ber), .evt_ch(evt_ch)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done_flag = 0;

   logic [31:0] mem_arr [256];
   bit stall_mode = 0;
   bit stall_tgl = 0;
   logic [31:0] fa_log [64];
   int fa_n = 0;
   int ev_kind [64];
   int ev_ch [64];
   int ev_n = 0;
   int multi_ev = 0;

   // Memory model: presents data on the falling edge while a request is up.
   always @(negedge clk) begin
      stall_tgl <= ~stall_tgl;
      if (mem_req && (!stall_mode || stall_tgl)) begin
         mem_valid <= 1'b1;
         mem_data  <= mem_arr[8'((mem_addr - BASE) >> 2)];
         if (fa_n < 64) fa_log[fa_n] = mem_addr;
         fa_n = fa_n + 1;
      end else begin
         mem_valid <= 1'b0;
      end
   end

   // Event logger.
   always @(negedge clk) begin
      if (($countones({evt_sof, evt_eof, evt_bs, evt_ber})) > 1) multi_ev = multi_ev + 1;
      if (evt_sof || evt_eof || evt_bs || evt_ber) begin
         if (ev_n < 64) begin
            ev_kind[ev_n] = evt_sof ? K_SOF : evt_eof ? K_EOF : evt_bs ? K_BS : K_BER;
            ev_ch[ev_n]   = int'(evt_ch);
         end
         ev_n = ev_n + 1;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input int ch, input int ofs, input logic [31:0] v);
      @(negedge clk);
      reg_addr  = 8'(ch * 32 + ofs);
      reg_wdata = v;
      reg_we    = 1'b1;
      @(negedge clk);
      reg_we    = 1'b0;
   endtask

   task automatic rd(input int ch, input int ofs, output logic [31:0] v);
      reg_addr = 8'(ch * 32 + ofs);
      #1;
      v = reg_rdata;
   endtask

   task automatic put_desc(input logic [31:0] a, input logic [31:0] l, input logic [31:0] s,
                           input logic [31:0] i, input logic [31:0] c);
      int k;
      k = int'((a - BASE) >> 2);
      mem_arr[k] = l; mem_arr[k+1] = s; mem_arr[k+2] = i; mem_arr[k+3] = c;
   endtask

   task automatic run_frame(input bit repulse);
      int cnt;
      ev_n = 0; fa_n = 0;
      @(negedge clk); frame_start = 1'b1;
      @(negedge clk); frame_start = 1'b0;
      chk("R9 busy after start", 32'(busy), 32'd1);
      if (repulse) begin
         @(negedge clk); frame_start = 1'b1;
         @(negedge clk); frame_start = 1'b0;
      end
      cnt = 0;
      while (busy && cnt < 2000) begin @(negedge clk); cnt++; end
      chk("R9 busy falls", 32'(busy), 32'd0);
      repeat (3) @(negedge clk);
   endtask

   task automatic chk_ev(input int i, input int k, input int c, input string tag);
      chk({tag, " kind"}, 32'(ev_kind[i]), 32'(k));
      chk({tag, " ch"},   32'(ev_ch[i]),   32'(c));
   endtask

   task automatic t_reset;
      logic [31:0] v;
      chk("R1 busy", 32'(busy), 0);
      chk("R1 mem_req", 32'(mem_req), 0);
      chk("R1 events", 32'({evt_sof, evt_eof, evt_bs, evt_ber}), 0);
      for (int c = 0; c < NCH; c++)
         for (int o = 0; o < 5; o++) begin
            rd(c, o * 4, v);
            chk("R1 reg zero", v, 0);
         end
   endtask

   task automatic t_regwrite;
      logic [31:0] v;
      wr(2, 0, 32'h1234_567F); rd(2, 0, v); chk("R2 link mask", v, 32'h1234_5670);
      wr(2, 4, 32'hFFFF_FFFF); rd(2, 4, v); chk("R2 branch mask", v, 32'hFFFF_FFF3);
      wr(2, 4, 32'h0);
      wr(2, 8, 32'hDEAD_BEEF); rd(2, 8, v); chk("R2 source write ignored", v, 0);
      wr(2, 12, 32'hDEAD_BEEF); rd(2, 12, v); chk("R2 id write ignored", v, 0);
      wr(2, 16, 32'hDEAD_BEEF); rd(2, 16, v); chk("R2 cmd write ignored", v, 0);
   endtask

   task automatic t_chain;
      logic [31:0] v;
      put_desc(BASE + 32'h40, BASE + 32'h80, BASE + 32'h200, 32'hAB, 32'h0060_0100);
      wr(0, 0, BASE + 32'h40);
      ch_en = 4'b0001;
      run_frame(0);
      chk("R10 word count", 32'(fa_n), 4);
      for (int k = 0; k < 4; k++) chk("R10 word address", fa_log[k], BASE + 32'h40 + 32'(4 * k));
      rd(0, 0, v);  chk("R4 link loaded", v, BASE + 32'h80);
      rd(0, 8, v);  chk("R4 source loaded", v, BASE + 32'h200);
      rd(0, 12, v); chk("R4 id loaded", v, 32'hAB);
      rd(0, 16, v); chk("R4 cmd loaded", v, 32'h0060_0100);
      chk("R7 both events count", 32'(ev_n), 2);
      chk_ev(0, K_SOF, 0, "R7 sof first");
      chk_ev(1, K_EOF, 0, "R7 eof second");
   endtask

   task automatic t_cmd_gate;
      logic [31:0] v;
      put_desc(BASE + 32'h80, BASE + 32'hA0, BASE + 32'h204, 32'h2, 32'h0020_0000);
      put_desc(BASE + 32'hA0, BASE + 32'h40, BASE + 32'h208, 32'h3, 32'h0);
      run_frame(0);
      chk("R4 follows chain", fa_log[0], BASE + 32'h80);
      chk("R7 eof only count", 32'(ev_n), 1);
      chk_ev(0, K_EOF, 0, "R7 eof only");
      run_frame(0);
      chk("R7 no events count", 32'(ev_n), 0);
      rd(0, 12, v); chk("R4 id after third", v, 32'h3);
   endtask

   task automatic t_branch;
      logic [31:0] v;
      put_desc(BASE + 32'hC0, BASE + 32'h40, BASE + 32'h210, 32'h4, 32'h0040_0000);
      put_desc(BASE + 32'hE0, BASE + 32'h40, BASE + 32'h214, 32'h5, 32'h0);
      wr(0, 4, BASE + 32'hC3);
      run_frame(0);
      chk("R3 branch address used", fa_log[0], BASE + 32'hC0);
      rd(0, 4, v);  chk("R3 request cleared, int kept", v, BASE + 32'hC2);
      rd(0, 12, v); chk("R3 branch descriptor id", v, 32'h4);
      chk("R3 event count", 32'(ev_n), 2);
      chk_ev(0, K_BS, 0, "R3 branch event");
      chk_ev(1, K_SOF, 0, "R3 sof after branch");
      wr(0, 4, BASE + 32'hE1);
      run_frame(0);
      chk("R3 second branch address", fa_log[0], BASE + 32'hE0);
      chk("R3 no branch event without flag", 32'(ev_n), 0);
      rd(0, 4, v);  chk("R3 request cleared again", v, BASE + 32'hE0);
   endtask

   task automatic t_ber_src;
      logic [31:0] v;
      put_desc(BASE + 32'h100, BASE + 32'h120, 32'h0, 32'h6, 32'h0060_0000);
      put_desc(BASE + 32'h120, BASE + 32'h40, 32'h0000_9000, 32'h7, 32'h0060_0000);
      wr(0, 0, BASE + 32'h100);
      run_frame(0);
      chk("R6 zero source one event", 32'(ev_n), 1);
      chk_ev(0, K_BER, 0, "R6 zero source");
      run_frame(0);
      chk("R6 outside source one event", 32'(ev_n), 1);
      chk_ev(0, K_BER, 0, "R6 outside source");
      rd(0, 8, v); chk("R6 source kept", v, 32'h0000_9000);
   endtask

   task automatic t_window;
      logic [31:0] v;
      wr(0, 0, BASE + SIZE);
      run_frame(0);
      chk("R5 no read above window", 32'(fa_n), 0);
      rd(0, 8, v); chk("R5 source cleared", v, 0);
      rd(0, 0, v); chk("R5 link unchanged", v, BASE + SIZE);
      chk("R5 event count", 32'(ev_n), 1);
      chk_ev(0, K_BER, 0, "R5 bus error");
      wr(0, 0, BASE - 32'h10);
      run_frame(0);
      chk("R5 no read below window", 32'(fa_n), 0);
      put_desc(BASE + SIZE - 32'h10, BASE + 32'h40, BASE + 32'h218, 32'h9, 32'h0);
      wr(0, 0, BASE + SIZE - 32'h10);
      run_frame(0);
      chk("R5 last slot fetched", 32'(fa_n), 4);
      chk("R5 last slot no events", 32'(ev_n), 0);
   endtask

   task automatic t_multi;
      logic [31:0] v;
      put_desc(BASE + 32'h140, BASE + 32'h140, BASE + 32'h220, 32'h7, 32'h0040_0000);
      put_desc(BASE + 32'h160, BASE + 32'h160, BASE + 32'h224, 32'h8, 32'h0020_0000);
      wr(0, 0, BASE + 32'h40);
      wr(1, 0, BASE + 32'h300);
      wr(2, 0, BASE + 32'h140);
      wr(3, 0, BASE + 32'h160);
      ch_en = 4'b1101;
      stall_mode = 1;
      run_frame(1);
      chk("R10 stalled word count", 32'(fa_n), 12);
      chk("R8 ch0 first", fa_log[0], BASE + 32'h40);
      chk("R8 ch2 second", fa_log[4], BASE + 32'h140);
      chk("R8 ch3 third", fa_log[8], BASE + 32'h160);
      chk("R10 last word", fa_log[11], BASE + 32'h16C);
      chk("R9 repeat start ignored", 32'(ev_n), 4);
      chk_ev(0, K_SOF, 0, "R8 ev0");
      chk_ev(1, K_EOF, 0, "R8 ev1");
      chk_ev(2, K_SOF, 2, "R8 ev2");
      chk_ev(3, K_EOF, 3, "R11 ev3 channel");
      rd(1, 0, v); chk("R8 disabled link kept", v, BASE + 32'h300);
      rd(2, 12, v); chk("R8 ch2 id", v, 32'h7);
      repeat (20) @(negedge clk);
      chk("R9 stays idle", 32'(busy), 0);
      chk("R11 single event per cycle", 32'(multi_ev), 0);
      stall_mode = 0;
      ch_en = '0;
   endtask

   task automatic finish_run;
      if (!done_flag) begin
         done_flag = 1;
         $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem_arr[i] = 32'h0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_regwrite;
      t_chain;
      t_cmd_gate;
      t_branch;
      t_ber_src;
      t_window;
      t_multi;
      finish_run;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run;
   end
endmodule